// File: doc/BRIEF.md
# Clocked Burst-Mode Controller

This block is a synchronous model of a six-state Mealy burst-mode controller. It watches three level inputs, A, B and C, and drives two level outputs, Y and Z. In each state it waits for one of the input bursts that leave that state. A burst is a set of input edges, and the edges may arrive in any order and spread over any number of clocks. When the last edge of a burst has been seen, the controller registers the matching output burst and moves to the next state.

The states are named ST0 to ST5. The transitions are:
- ST0 -> ST1 on A+C+, output Z-.
- ST0 -> ST3 on A+B+, output Y+Z-.
- ST1 -> ST2 on C-, output Z+.
- ST2 -> ST4 on C+, output Y+.
- ST3 -> ST4 on B-C+, output Z+.
- ST4 -> ST5 on A-, output Y-.
- ST5 -> ST0 on C-, with an empty output burst.

Any input behaviour outside these bursts sets a sticky error flag and freezes the machine until reset. This covers an edge that belongs to no burst of the current state, an edge that reverses after it has arrived, and an edge that comes too soon after a transition. The inputs must already be synchronous to the clock.

Top module: `bm_ctrl`

## Requirements
- R1: After reset the outputs are Y=0, Z=1 and the error flag is 0. The inputs are expected at A=B=C=0, and the machine is in ST0.
- R2: In ST0, the burst A+C+ gives Y=0, Z=0 (ST1). The burst A+B+ gives Y=1, Z=0 (ST3).
- R3: The remaining arcs and the outputs after each are:
  - ST1 on C-: YZ=01 (ST2).
  - ST2 on C+: YZ=11 (ST4).
  - ST3 on B-C+: YZ=11 (ST4).
  - ST4 on A-: YZ=01 (ST5).
  - ST5 on C-: YZ=01 (ST0), with no output change.
- R4: The edges of a burst are accepted in any order, one per clock, with idle clocks between them, or several in the same clock. Y and Z do not change until the burst is complete.
- R5: Y and Z and the state update on the clock edge that samples the last edge of the burst. Y and Z never change on an edge where the state holds.
- R6: An input change that is part of no burst of the current state sets the error flag on the clock edge that samples it. An example is C rising after B in ST0. A lone B+ in ST0 is legal, because it belongs to A+B+.
- R7: An input edge that has arrived and then reverses before its burst completes sets the error flag.
- R8: Inputs must hold for the one clock after a transition. An input that differs from its value at the transition, when sampled on the next edge, sets the error flag.
- R9: The error flag stays set until reset. While it is set, Y, Z and the state ignore the inputs.
- R10: ST4 is entered with A=1, B=0, C=1 and YZ=11 on both of its incoming arcs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_i | input | 1 | Level input A |
| b_i | input | 1 | Level input B |
| c_i | input | 1 | Level input C |
| y_o | output | 1 | Registered output Y |
| z_o | output | 1 | Registered output Z |
| err_o | output | 1 | Sticky specification-violation flag |

## Verification
The bench builds the block with its default parameters: three inputs, two outputs and two arc slots per state. These cover every arc of the six-state graph, including the two-way choice in ST0 where one burst has the subset prefix of the other. A random walk picks arcs and splits every burst into random edge orders, idle gaps and same-clock groups, so both entry paths into ST4 and the empty burst back to ST0 are taken many times. Directed cases drive the three kinds of violation and the frozen behaviour after an error.

// File: rtl/bm_pkg.sv
package bm_pkg;
    localparam int NIN  = 3;   // inputs, A is the MSB
    localparam int NOUT = 2;   // outputs, Y is the MSB
    localparam int NARC = 2;   // arc slots per state

    localparam logic [NIN-1:0]  RESET_ABC = 3'b000;
    localparam logic [NOUT-1:0] RESET_YZ  = 2'b01;

    typedef enum logic [2:0] {
        ST0 = 3'd0, ST1 = 3'd1, ST2 = 3'd2,
        ST3 = 3'd3, ST4 = 3'd4, ST5 = 3'd5
    } bm_state_e;

    typedef struct packed {
        logic            valid;
        logic [NIN-1:0]  mask;   // inputs that toggle in this burst
        bm_state_e       nxt;
        logic [NOUT-1:0] yz;     // output values after the burst
    } bm_arc_t;
endpackage

// File: rtl/bm_arc_table.sv
module bm_arc_table
    import bm_pkg::*;
#(
    parameter int ARCS = NARC
) (
    input  bm_state_e              state,
    output bm_arc_t [ARCS-1:0]     arcs
);
    always_comb begin
        arcs = '0;
        unique case (state)
            ST0: begin
                arcs[0] = '{valid: 1'b1, mask: 3'b101, nxt: ST1, yz: 2'b00};
                arcs[1] = '{valid: 1'b1, mask: 3'b110, nxt: ST3, yz: 2'b10};
            end
            ST1: arcs[0] = '{valid: 1'b1, mask: 3'b001, nxt: ST2, yz: 2'b01};
            ST2: arcs[0] = '{valid: 1'b1, mask: 3'b001, nxt: ST4, yz: 2'b11};
            ST3: arcs[0] = '{valid: 1'b1, mask: 3'b011, nxt: ST4, yz: 2'b11};
            ST4: arcs[0] = '{valid: 1'b1, mask: 3'b100, nxt: ST5, yz: 2'b01};
            ST5: arcs[0] = '{valid: 1'b1, mask: 3'b001, nxt: ST0, yz: 2'b01};
            default: arcs = '0;
        endcase
    end
endmodule

// File: rtl/bm_edge_tracker.sv
module bm_edge_tracker
    import bm_pkg::*;
#(
    parameter int W = NIN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_v,
    input  logic         go,
    input  logic         hold,
    output logic [W-1:0] diff,
    output logic [W-1:0] seen,
    output logic [W-1:0] base,
    output logic         settle
);
    logic [W-1:0] base_q, seen_q;
    logic         settle_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= RESET_ABC;
            seen_q   <= '0;
            settle_q <= 1'b0;
        end else if (!hold) begin
            settle_q <= go;
            if (go) begin
                base_q <= in_v;
                seen_q <= '0;
            end else begin
                seen_q <= seen_q | diff;
            end
        end
    end

    assign diff   = in_v ^ base_q;
    assign seen   = seen_q;
    assign base   = base_q;
    assign settle = settle_q;
endmodule

// File: rtl/bm_burst_judge.sv
module bm_burst_judge
    import bm_pkg::*;
#(
    parameter int ARCS = NARC,
    parameter int W    = NIN
) (
    input  bm_arc_t [ARCS-1:0] arcs,
    input  logic [W-1:0]       diff,
    input  logic [W-1:0]       seen,
    input  logic               settle,
    output logic               viol,
    output logic               fire,
    output bm_state_e          nxt,
    output logic [NOUT-1:0]    yz_nx
);
    logic [ARCS-1:0] fits, done;

    for (genvar i = 0; i < ARCS; i++) begin : g_arc
        assign fits[i] = arcs[i].valid && ((diff & ~arcs[i].mask) == '0);
        assign done[i] = arcs[i].valid && (diff == arcs[i].mask);
    end

    always_comb begin
        viol = (settle && (diff != '0))
            || ((diff != '0) && (fits == '0))
            || ((seen & ~diff) != '0);
        fire  = !viol && (done != '0);
        nxt   = arcs[0].nxt;
        yz_nx = arcs[0].yz;
        for (int i = ARCS - 1; i >= 0; i--) begin
            if (done[i]) begin
                nxt   = arcs[i].nxt;
                yz_nx = arcs[i].yz;
            end
        end
    end
endmodule

// File: rtl/bm_ctrl.sv
module bm_ctrl
    import bm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic y_o,
    output logic z_o,
    output logic err_o
);
    logic [NIN-1:0]      abc;
    logic [NIN-1:0]      diff, seen, base_w;
    logic                settle_w, viol, fire, go, err_q;
    logic [NOUT-1:0]     yz_q, yz_nx;
    bm_state_e           state_q, nxt;
    bm_arc_t [NARC-1:0]  arcs;

    assign abc = {a_i, b_i, c_i};
    assign go  = fire && !err_q;

    bm_arc_table #(.ARCS(NARC)) u_tbl (
        .state (state_q),
        .arcs  (arcs)
    );

    bm_edge_tracker #(.W(NIN)) u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_v   (abc),
        .go     (go),
        .hold   (err_q),
        .diff   (diff),
        .seen   (seen),
        .base   (base_w),
        .settle (settle_w)
    );

    bm_burst_judge #(.ARCS(NARC), .W(NIN)) u_jdg (
        .arcs   (arcs),
        .diff   (diff),
        .seen   (seen),
        .settle (settle_w),
        .viol   (viol),
        .fire   (fire),
        .nxt    (nxt),
        .yz_nx  (yz_nx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)  state_q <= ST0;
        else if (go) state_q <= nxt;
    end

    // output and error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            yz_q  <= RESET_YZ;
            err_q <= 1'b0;
        end else begin
            if (go)   yz_q  <= yz_nx;
            if (viol) err_q <= 1'b1;
        end
    end

    assign y_o   = yz_q[1];
    assign z_o   = yz_q[0];
    assign err_o = err_q;
endmodule

// File: rtl/bm_ctrl_chk.sv
module bm_ctrl_chk
    import bm_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [NIN-1:0] abc,
    input logic [NIN-1:0] base_w,
    input logic           settle_w,
    input bm_state_e      state_q,
    input logic           y_o,
    input logic           z_o,
    input logic           err_o
);
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> ($stable(state_q) && $stable({y_o, z_o})));

    a_r5_yz_with_state: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(state_q) |-> $stable({y_o, z_o}));

    a_r10_st4_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST4 && !$stable(state_q)) |-> (y_o && z_o && base_w == 3'b101));

    a_r8_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_w && abc != base_w) |=> err_o);
endmodule

bind bm_ctrl bm_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .abc      (abc),
    .base_w   (base_w),
    .settle_w (settle_w),
    .state_q  (state_q),
    .y_o      (y_o),
    .z_o      (z_o),
    .err_o    (err_o)
);

// File: tb/bm_ctrl_tb.sv
module bm_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] abc = 3'b000;
    logic y, z, err;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bm_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_i(abc[2]), .b_i(abc[1]), .c_i(abc[0]),
        .y_o(y), .z_o(z), .err_o(err)
    );

    // reference spec: outputs per state
    function automatic logic [1:0] yz_of(int s);
        case (s)
            0: return 2'b01; 1: return 2'b00; 2: return 2'b01;
            3: return 2'b10; 4: return 2'b11; default: return 2'b01;
        endcase
    endfunction

    // absolute input value at the end of an arc
    function automatic logic [2:0] tgt_of(int s, int k);
        case (s)
            0: return (k == 0) ? 3'b101 : 3'b110;
            1: return 3'b100;
            2: return 3'b101;
            3: return 3'b101;
            4: return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    function automatic int nxt_of(int s, int k);
        case (s)
            0: return (k == 0) ? 1 : 3;
            1: return 2; 2: return 4; 3: return 4; 4: return 5;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        abc   = 3'b000;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // walk one arc from state s, inputs currently at cur
    task automatic walk_arc(input int s, input int k, inout logic [2:0] cur);
        logic [2:0] rem, pick;
        int nb, sel;
        rem = cur ^ tgt_of(s, k);
        while (rem != 3'b000) begin
            repeat ($urandom_range(0, 2)) @(negedge clk);
            if ($urandom_range(0, 3) == 0) begin
                pick = rem;
            end else begin
                nb = $countones(rem);
                sel = $urandom_range(0, nb - 1);
                pick = 3'b000;
                for (int b = 0; b < 3; b++) begin
                    if (rem[b]) begin
                        if (sel == 0) pick[b] = 1'b1;
                        sel--;
                    end
                end
            end
            rem = rem & ~pick;
            cur = cur ^ pick;
            abc = cur;
            @(negedge clk);
            if (rem != 3'b000) begin
                chk({y, z} == yz_of(s) && !err, "R4 partial burst",
                    {err, y, z}, {1'b0, yz_of(s)});
            end else begin
                chk({y, z} == yz_of(nxt_of(s, k)) && !err,
                    (s == 0) ? "R2 arc from ST0" : "R3 arc",
                    {err, y, z}, {1'b0, yz_of(nxt_of(s, k))});
                if (nxt_of(s, k) == 4)
                    chk(cur == 3'b101 && {y, z} == 2'b11, "R10 ST4 entry",
                        {cur}, 3'b101);
                @(negedge clk);   // settle clock
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [2:0] cur;
        int s, k;
        void'($urandom(32'h5eed_0123));

        // R1 reset state
        do_reset();
        @(negedge clk);
        chk({y, z} == 2'b01 && !err, "R1 reset", {err, y, z}, 3'b001);

        // R6 lone B+ legal, then C+ illegal in ST0
        abc = 3'b010; @(negedge clk);
        chk(!err && {y, z} == 2'b01, "R6 lone B+ legal", {err, y, z}, 3'b001);
        abc = 3'b011; @(negedge clk);
        chk(err && {y, z} == 2'b01, "R6 B+C+ flagged", {err, y, z}, 3'b101);

        // R9 sticky and inputs ignored: drive the rest of A+B+
        abc = 3'b110; repeat (3) @(negedge clk);
        chk(err && {y, z} == 2'b01, "R9 frozen after error", {err, y, z}, 3'b101);
        abc = 3'b000; repeat (2) @(negedge clk);
        chk(err, "R9 sticky", {2'b0, err}, 3'b001);

        // R7 reversal of an arrived edge
        do_reset();
        abc = 3'b100; @(negedge clk);
        chk(!err && {y, z} == 2'b01, "R4 A+ alone waits", {err, y, z}, 3'b001);
        abc = 3'b000; @(negedge clk);
        chk(err && {y, z} == 2'b01, "R7 reversal flagged", {err, y, z}, 3'b101);

        // R8 edge in the clock right after a transition
        do_reset();
        abc = 3'b101; @(negedge clk);
        chk({y, z} == 2'b00 && !err, "R5 outputs one clock after last edge", {err, y, z}, 3'b000);
        abc = 3'b100; @(negedge clk);
        chk(err && {y, z} == 2'b00, "R8 early edge flagged", {err, y, z}, 3'b100);

        // R3 directed full loop via ST3 with empty burst back to ST0
        do_reset();
        cur = 3'b000;
        walk_arc(0, 1, cur);
        walk_arc(3, 0, cur);
        walk_arc(4, 0, cur);
        walk_arc(5, 0, cur);
        chk({y, z} == 2'b01 && cur == 3'b000, "R3 empty burst to ST0", {err, y, z}, 3'b001);

        // random walk
        do_reset();
        cur = 3'b000;
        s = 0;
        for (int it = 0; it < 200; it++) begin
            k = (s == 0) ? int'($urandom_range(0, 1)) : 0;
            walk_arc(s, k, cur);
            s = nxt_of(s, k);
        end
        chk(!err, "R4 random walk clean", {2'b0, err}, 3'b000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule